// File: doc/BRIEF.md
# Display Controller Control/Status Register Bank

This block is the software-visible register bank of a display controller. A processor reaches it over a 16-bit register bus that addresses halfwords and carries one write enable for each byte lane. It holds the interrupt pending and enable words and the display and drawing control bits. It also holds four brightness/rest words, a frame-cycle count, a column-table pointer pair, four window words, a background colour and eight small palette registers. Each register keeps only the bits it defines, and each applies its own rule to partial writes.

The bank sends its control bits to the display and drawing engines. It takes their status flags back in, registers them once per clock, and returns them in two status words. Interrupt sources set pending bits through a pulse input. One registered request output tells the processor that at least one enabled source is waiting. Reads are combinational from the registered state and return the whole halfword, whatever the lane enables are. Writes take effect on the clock edge at which the write strobe is high.

Top module: `vrf_regfile`

## Requirements
- R1: The interrupt-enable register (halfword address 0x01) keeps only the bits under mask 0xE01F. Each byte lane updates only when its enable is set, and every bit outside the mask reads as zero.
- R2: A write to the interrupt-clear address (0x02, which reads as zero) clears each pending bit that is set in the enabled lanes of the written value. Pending bits are set by `irq_evt` pulses, and a set wins over a clear of the same bit in the same cycle. The pending word reads at address 0x00.
- R3: `irq` rises at the same clock edge that leaves some pending bit set together with its enable bit. It then stays high, even if the enables are removed, until every pending bit is zero.
- R4: Each palette register (addresses 0x18 to 0x1F) stores three 2-bit entries at bits 3:2, 5:4 and 7:6. Bits 1:0 and 15:8 read as zero.
- R5: A palette write whose low-lane enable (`bus_be[0]`) is clear leaves that palette unchanged, whatever the high lane carries.
- R6: The frame-cycle register (0x06) keeps bits 3:0 and the background-colour register (0x0A) keeps bits 1:0. Both update only from the low lane.
- R7: The window registers (0x10 to 0x13) are 10 bits wide, the brightness/rest registers (0x0C to 0x0F) are 16 bits wide, and the column-table register (0x07) is two 8-bit bytes. In all of them each byte lane updates independently.
- R8: A write to the display-control address (0x04, which reads as zero) sets lock, sync-enable and refresh-enable from bits 10, 9 and 8 through the high lane, and display-enable from bit 1 through the low lane. The display status word (0x03) returns lock at bit 10, sync at 9, refresh at 8, frame clock at 7, scan-ready at 6, `stat_buf_busy[3:0]` at bits 5:2 and display-enable at bit 1.
- R9: A write to the drawing-control address (0x09, which reads as zero) takes a 5-bit group compare from bits 12:8 through the high lane and drawing-enable from bit 1 through the low lane. The drawing status word (0x08) returns group-output at bit 15, the group counter at 12:8, overtime at 4, `stat_fb_busy[1:0]` at 3:2 and drawing-enable at 1.
- R10: Address 0x05 reads as the constant 2. Addresses 0x0B, 0x14 to 0x17 and 0x20 and above read as zero. Writes to unmapped or read-only addresses change no state.
- R11: A synchronous active-high reset clears every register, the sampled status and `irq`.
- R12: Status inputs appear in the status words one clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane write enables (bit 1 = bits 15:8) |
| bus_addr | input | ADDR_W | Halfword register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_evt | input | 16 | Interrupt source pulses, one per pending bit |
| irq | output | 1 | Interrupt request |
| stat_fclk | input | 1 | Frame clock status |
| stat_scan_rdy | input | 1 | Scanner ready status |
| stat_buf_busy | input | 4 | Buffer busy: [0] left0, [1] right0, [2] left1, [3] right1 |
| stat_overtime | input | 1 | Drawing overtime flag |
| stat_fb_busy | input | 2 | Frame-buffer drawing busy flags |
| stat_group_out | input | 1 | Group output flag |
| stat_group_cnt | input | 5 | Current group counter |
| ctl_disp_en | output | 1 | Display enable |
| ctl_refresh_en | output | 1 | Refresh enable |
| ctl_sync_en | output | 1 | Sync enable |
| ctl_lock | output | 1 | Lock bit |
| ctl_draw_en | output | 1 | Drawing enable |
| ctl_group_cmp | output | 5 | Group compare value |

## Verification
The assertions watch a fixed set of properties on every cycle. They check the request line against the pending and enable words, and they check that the request falls only when pending is empty. They check that a full enable write keeps only its masked bits and that a full clear write empties the bits it names. They also check that palettes stay stable under writes without the low lane, that palette and unmapped reads are zero where they must be, and that the version word is constant. The bench's scenarios cover the rest. They show lane-by-lane merging in each register width, the order of a set and a clear in the same cycle, the request staying high after its enables are removed, the one-edge lag of the status inputs, and the state left after a reset in the middle of a run. A behavioural model compares every output on every clock, including through a long random phase.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam int DATA_W = 16;

    // Halfword address map
    localparam int A_PEND     = 0;
    localparam int A_INTEN    = 1;
    localparam int A_INTCLR   = 2;
    localparam int A_DSTAT    = 3;
    localparam int A_DCTRL    = 4;
    localparam int A_VERSION  = 5;
    localparam int A_FRMCYC   = 6;
    localparam int A_COLTAB   = 7;
    localparam int A_XSTAT    = 8;
    localparam int A_XCTRL    = 9;
    localparam int A_BKG      = 10;
    localparam int A_BRT_BASE = 12;
    localparam int A_WIN_BASE = 16;
    localparam int A_PAL_BASE = 24;

    localparam logic [DATA_W-1:0] INT_EN_MASK = 16'hE01F;
    localparam logic [DATA_W-1:0] VERSION_ID  = 16'd2;

    typedef struct packed {
        logic lock;
        logic sync_en;
        logic refresh_en;
        logic disp_en;
    } disp_ctrl_t;

    typedef struct packed {
        logic [4:0] group_cmp;
        logic       draw_en;
    } draw_ctrl_t;

    typedef struct packed {
        logic       fclk;
        logic       scan_rdy;
        logic [3:0] buf_busy;
        logic       group_out;
        logic [4:0] group_cnt;
        logic       overtime;
        logic [1:0] fb_busy;
    } stat_in_t;

    // Expand the two lane enables into a 16-bit bit mask
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Replace only the enabled lanes of old_v with new_v
    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [1:0]        be);
        return (old_v & ~lane_mask(be)) | (new_v & lane_mask(be));
    endfunction

endpackage

// File: rtl/vrf_lane_regs.sv
module vrf_lane_regs #(
    parameter int NUM   = 4,
    parameter int WIDTH = 16,
    localparam int LANES = (WIDTH + 7) / 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM-1:0]             wr_sel,
    input  logic [LANES-1:0]           be,
    input  logic [WIDTH-1:0]           wdata,
    output logic [NUM-1:0][WIDTH-1:0]  q
);

    for (genvar r = 0; r < NUM; r++) begin : g_reg
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[r][b] <= 1'b0;
                end else if (wr_sel[r] && be[b / 8]) begin
                    q[r][b] <= wdata[b];
                end
            end
        end
    end

endmodule

// File: rtl/vrf_palette_bank.sv
module vrf_palette_bank #(
    parameter int NUM      = 8,
    parameter int ENTRIES  = 3,
    parameter int ENTRY_W  = 2,
    localparam int FIELD_W = ENTRIES * ENTRY_W,
    localparam int READ_W  = FIELD_W + ENTRY_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM-1:0]              wr_sel,
    input  logic                        lo_lane,
    input  logic [FIELD_W-1:0]          wfield,
    output logic [NUM-1:0][READ_W-1:0]  rd_val
);

    for (genvar p = 0; p < NUM; p++) begin : g_pal
        logic [ENTRIES-1:0][ENTRY_W-1:0] ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_sel[p] && lo_lane) begin
                ent_q <= wfield;
            end
        end

        // Entry 0 slot is never stored and reads as zero
        assign rd_val[p] = {ent_q, {ENTRY_W{1'b0}}};
    end

endmodule

// File: rtl/vrf_irq_ctrl.sv
module vrf_irq_ctrl
    import vrf_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK = INT_EN_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              clr_wr,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] en_q,
    output logic              irq
);

    logic [DATA_W-1:0] en_d;
    logic [DATA_W-1:0] pend_d;
    logic              irq_d;

    always_comb begin
        en_d = en_q;
        if (en_wr) begin
            en_d = lane_merge(en_q, wdata, be) & MASK;
        end
        pend_d = pend_q;
        if (clr_wr) begin
            pend_d = pend_d & ~(wdata & lane_mask(be));
        end
        pend_d = pend_d | evt;

        // Latched request: set by any enabled pending bit, released only when empty
        if (|(pend_d & en_d)) begin
            irq_d = 1'b1;
        end else if (pend_d == '0) begin
            irq_d = 1'b0;
        end else begin
            irq_d = irq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            irq    <= 1'b0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
            irq    <= irq_d;
        end
    end

endmodule

// File: rtl/vrf_regfile.sv
module vrf_regfile
    import vrf_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NUM_BRT = 4,
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 10,
    parameter int NUM_PAL = 8,
    parameter int FRM_W   = 4,
    parameter int BKG_W   = 2,
    localparam int WIN_LANES = (WIN_W + 7) / 8,
    localparam int FRM_LANES = (FRM_W + 7) / 8,
    localparam int BKG_LANES = (BKG_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       irq_evt,
    output logic              irq,
    input  logic              stat_fclk,
    input  logic              stat_scan_rdy,
    input  logic [3:0]        stat_buf_busy,
    input  logic              stat_overtime,
    input  logic [1:0]        stat_fb_busy,
    input  logic              stat_group_out,
    input  logic [4:0]        stat_group_cnt,
    output logic              ctl_disp_en,
    output logic              ctl_refresh_en,
    output logic              ctl_sync_en,
    output logic              ctl_lock,
    output logic              ctl_draw_en,
    output logic [4:0]        ctl_group_cmp
);

    // ---------------- write decode ----------------
    logic               sel_inten, sel_intclr, sel_dctrl, sel_xctrl;
    logic               sel_frm, sel_col, sel_bkg;
    logic [NUM_BRT-1:0] sel_brt;
    logic [NUM_WIN-1:0] sel_win;
    logic [NUM_PAL-1:0] sel_pal;

    always_comb begin
        sel_inten  = bus_wr && (bus_addr == ADDR_W'(A_INTEN));
        sel_intclr = bus_wr && (bus_addr == ADDR_W'(A_INTCLR));
        sel_dctrl  = bus_wr && (bus_addr == ADDR_W'(A_DCTRL));
        sel_xctrl  = bus_wr && (bus_addr == ADDR_W'(A_XCTRL));
        sel_frm    = bus_wr && (bus_addr == ADDR_W'(A_FRMCYC));
        sel_col    = bus_wr && (bus_addr == ADDR_W'(A_COLTAB));
        sel_bkg    = bus_wr && (bus_addr == ADDR_W'(A_BKG));
        for (int i = 0; i < NUM_BRT; i++) begin
            sel_brt[i] = bus_wr && (bus_addr == ADDR_W'(A_BRT_BASE + i));
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            sel_win[i] = bus_wr && (bus_addr == ADDR_W'(A_WIN_BASE + i));
        end
        for (int i = 0; i < NUM_PAL; i++) begin
            sel_pal[i] = bus_wr && (bus_addr == ADDR_W'(A_PAL_BASE + i));
        end
    end

    // ---------------- interrupt block ----------------
    logic [15:0] pend_q;
    logic [15:0] inten_q;

    vrf_irq_ctrl #(.MASK(INT_EN_MASK)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (sel_inten),
        .clr_wr (sel_intclr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .evt    (irq_evt),
        .pend_q (pend_q),
        .en_q   (inten_q),
        .irq    (irq)
    );

    // ---------------- lane-written data registers ----------------
    logic [NUM_BRT-1:0][15:0]      brt_q;
    logic [NUM_WIN-1:0][WIN_W-1:0] win_q;
    logic [0:0][FRM_W-1:0]         frm_q;
    logic [0:0][BKG_W-1:0]         bkg_q;
    logic [0:0][15:0]              col_q;

    vrf_lane_regs #(.NUM(NUM_BRT), .WIDTH(16)) u_brt (
        .clk(clk), .rst(rst), .wr_sel(sel_brt), .be(bus_be),
        .wdata(bus_wdata), .q(brt_q)
    );

    vrf_lane_regs #(.NUM(NUM_WIN), .WIDTH(WIN_W)) u_win (
        .clk(clk), .rst(rst), .wr_sel(sel_win), .be(bus_be[WIN_LANES-1:0]),
        .wdata(bus_wdata[WIN_W-1:0]), .q(win_q)
    );

    vrf_lane_regs #(.NUM(1), .WIDTH(FRM_W)) u_frm (
        .clk(clk), .rst(rst), .wr_sel(sel_frm), .be(bus_be[FRM_LANES-1:0]),
        .wdata(bus_wdata[FRM_W-1:0]), .q(frm_q)
    );

    vrf_lane_regs #(.NUM(1), .WIDTH(BKG_W)) u_bkg (
        .clk(clk), .rst(rst), .wr_sel(sel_bkg), .be(bus_be[BKG_LANES-1:0]),
        .wdata(bus_wdata[BKG_W-1:0]), .q(bkg_q)
    );

    vrf_lane_regs #(.NUM(1), .WIDTH(16)) u_col (
        .clk(clk), .rst(rst), .wr_sel(sel_col), .be(bus_be),
        .wdata(bus_wdata), .q(col_q)
    );

    // ---------------- palettes ----------------
    logic [NUM_PAL-1:0][7:0] pal_rd;

    vrf_palette_bank #(.NUM(NUM_PAL), .ENTRIES(3), .ENTRY_W(2)) u_pal (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (sel_pal),
        .lo_lane (bus_be[0]),
        .wfield  (bus_wdata[7:2]),
        .rd_val  (pal_rd)
    );

    // ---------------- display and drawing control ----------------
    disp_ctrl_t dctl_q;
    draw_ctrl_t xctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dctl_q <= '0;
            xctl_q <= '0;
        end else begin
            if (sel_dctrl && bus_be[1]) begin
                dctl_q.lock       <= bus_wdata[10];
                dctl_q.sync_en    <= bus_wdata[9];
                dctl_q.refresh_en <= bus_wdata[8];
            end
            if (sel_dctrl && bus_be[0]) begin
                dctl_q.disp_en <= bus_wdata[1];
            end
            if (sel_xctrl && bus_be[1]) begin
                xctl_q.group_cmp <= bus_wdata[12:8];
            end
            if (sel_xctrl && bus_be[0]) begin
                xctl_q.draw_en <= bus_wdata[1];
            end
        end
    end

    assign ctl_disp_en    = dctl_q.disp_en;
    assign ctl_refresh_en = dctl_q.refresh_en;
    assign ctl_sync_en    = dctl_q.sync_en;
    assign ctl_lock       = dctl_q.lock;
    assign ctl_draw_en    = xctl_q.draw_en;
    assign ctl_group_cmp  = xctl_q.group_cmp;

    // ---------------- status sampling ----------------
    stat_in_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.fclk      <= stat_fclk;
            stat_q.scan_rdy  <= stat_scan_rdy;
            stat_q.buf_busy  <= stat_buf_busy;
            stat_q.group_out <= stat_group_out;
            stat_q.group_cnt <= stat_group_cnt;
            stat_q.overtime  <= stat_overtime;
            stat_q.fb_busy   <= stat_fb_busy;
        end
    end

    // ---------------- read mux ----------------
    logic [15:0] dstat_word;
    logic [15:0] xstat_word;

    always_comb begin
        dstat_word = {5'b0, dctl_q.lock, dctl_q.sync_en, dctl_q.refresh_en,
                      stat_q.fclk, stat_q.scan_rdy, stat_q.buf_busy,
                      dctl_q.disp_en, 1'b0};
        xstat_word = {stat_q.group_out, 2'b0, stat_q.group_cnt, 3'b0,
                      stat_q.overtime, stat_q.fb_busy, xctl_q.draw_en, 1'b0};
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_PEND):    bus_rdata = pend_q;
            ADDR_W'(A_INTEN):   bus_rdata = inten_q;
            ADDR_W'(A_DSTAT):   bus_rdata = dstat_word;
            ADDR_W'(A_VERSION): bus_rdata = VERSION_ID;
            ADDR_W'(A_FRMCYC):  bus_rdata = 16'(frm_q[0]);
            ADDR_W'(A_COLTAB):  bus_rdata = col_q[0];
            ADDR_W'(A_XSTAT):   bus_rdata = xstat_word;
            ADDR_W'(A_BKG):     bus_rdata = 16'(bkg_q[0]);
            default:            bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_BRT; i++) begin
            if (bus_addr == ADDR_W'(A_BRT_BASE + i)) bus_rdata = brt_q[i];
        end
        for (int i = 0; i < NUM_WIN; i++) begin
            if (bus_addr == ADDR_W'(A_WIN_BASE + i)) bus_rdata = 16'(win_q[i]);
        end
        for (int i = 0; i < NUM_PAL; i++) begin
            if (bus_addr == ADDR_W'(A_PAL_BASE + i)) bus_rdata = {8'h00, pal_rd[i]};
        end
    end

endmodule

// File: rtl/vrf_regfile_checker.sv
module vrf_regfile_checker
    import vrf_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int NUM_BRT = 4,
    parameter int NUM_WIN = 4,
    parameter int NUM_PAL = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr,
    input logic [1:0]              bus_be,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [15:0]             bus_wdata,
    input logic [15:0]             bus_rdata,
    input logic [15:0]             irq_evt,
    input logic                    irq,
    input logic [15:0]             pend_q,
    input logic [15:0]             inten_q,
    input logic [NUM_PAL-1:0][7:0] pal_rd
);

    function automatic logic is_unmapped(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        return !((v <= A_BKG) ||
                 (v >= A_BRT_BASE && v < A_BRT_BASE + NUM_BRT) ||
                 (v >= A_WIN_BASE && v < A_WIN_BASE + NUM_WIN) ||
                 (v >= A_PAL_BASE && v < A_PAL_BASE + NUM_PAL));
    endfunction

    function automatic logic is_palette(input logic [ADDR_W-1:0] a);
        return (int'(a) >= A_PAL_BASE) && (int'(a) < A_PAL_BASE + NUM_PAL);
    endfunction

    // R1: a full-width enable write keeps exactly the masked bits
    assert_inten_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_be == 2'b11 && bus_addr == ADDR_W'(A_INTEN))
        |=> (inten_q == ($past(bus_wdata) & INT_EN_MASK)));

    // R2: a full-width clear with no new events empties the named bits
    assert_clear_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_be == 2'b11 && bus_addr == ADDR_W'(A_INTCLR) && irq_evt == '0)
        |=> ((pend_q & $past(bus_wdata)) == '0));

    // R3: an enabled pending bit always has the request raised
    assert_irq_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (|(pend_q & inten_q)) |-> irq);

    // R3: the request is never high with nothing pending
    assert_irq_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> !irq);

    // R3: the request only falls when pending is empty
    assert_irq_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> (pend_q == '0));

    // R5: writes without the low lane never disturb palettes
    assert_pal_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_be[0]) |=> $stable(pal_rd));

    // R4: palette reads carry no bits outside 7:2
    assert_pal_fields_R4: assert property (@(posedge clk) disable iff (rst)
        is_palette(bus_addr) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[1:0] == 2'b00));

    // R10: version constant and unmapped zero
    assert_version_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(A_VERSION)) |-> (bus_rdata == VERSION_ID));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
        is_unmapped(bus_addr) |-> (bus_rdata == '0));

endmodule

bind vrf_regfile vrf_regfile_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_BRT (NUM_BRT),
    .NUM_WIN (NUM_WIN),
    .NUM_PAL (NUM_PAL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_evt   (irq_evt),
    .irq       (irq),
    .pend_q    (pend_q),
    .inten_q   (inten_q),
    .pal_rd    (pal_rd)
);

// File: tb/vrf_regfile_test.sv
module vrf_regfile_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_be;
    logic [5:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] irq_evt;
    logic        irq;
    logic        stat_fclk, stat_scan_rdy, stat_overtime, stat_group_out;
    logic [3:0]  stat_buf_busy;
    logic [1:0]  stat_fb_busy;
    logic [4:0]  stat_group_cnt;
    logic        ctl_disp_en, ctl_refresh_en, ctl_sync_en, ctl_lock, ctl_draw_en;
    logic [4:0]  ctl_group_cmp;

    always #4 clk = ~clk;   // 8 ns period

    vrf_regfile uut (.*);

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_pend, m_en, m_col, m_frm, m_bkg;
    logic        m_irq, m_lock, m_sync, m_ref, m_disp, m_draw;
    logic [4:0]  m_gcmp;
    logic [15:0] m_brt [4];
    logic [15:0] m_win [4];
    logic [15:0] m_pal [8];
    logic [15:0] m_dstat_in, m_xstat_in;   // sampled status, already positioned

    always @(posedge clk) begin
        logic [15:0] lm, clr;
        int a;
        if (rst) begin
            m_pend = 0; m_en = 0; m_col = 0; m_frm = 0; m_bkg = 0;
            m_irq = 0; m_lock = 0; m_sync = 0; m_ref = 0; m_disp = 0; m_draw = 0;
            m_gcmp = 0; m_dstat_in = 0; m_xstat_in = 0;
            for (int i = 0; i < 4; i++) begin m_brt[i] = 0; m_win[i] = 0; end
            for (int i = 0; i < 8; i++) m_pal[i] = 0;
        end else begin
            lm  = {{8{bus_be[1]}}, {8{bus_be[0]}}};
            clr = 0;
            a   = int'(bus_addr);
            if (bus_wr) begin
                if (a == 1) m_en = ((m_en & ~lm) | (bus_wdata & lm)) & 16'hE01F;
                if (a == 2) clr = bus_wdata & lm;
                if (a == 4) begin
                    if (bus_be[1]) begin
                        m_lock = bus_wdata[10]; m_sync = bus_wdata[9]; m_ref = bus_wdata[8];
                    end
                    if (bus_be[0]) m_disp = bus_wdata[1];
                end
                if (a == 6) m_frm = ((m_frm & ~lm) | (bus_wdata & lm)) & 16'h000F;
                if (a == 7) m_col = (m_col & ~lm) | (bus_wdata & lm);
                if (a == 9) begin
                    if (bus_be[1]) m_gcmp = bus_wdata[12:8];
                    if (bus_be[0]) m_draw = bus_wdata[1];
                end
                if (a == 10) m_bkg = ((m_bkg & ~lm) | (bus_wdata & lm)) & 16'h0003;
                if (a >= 12 && a < 16) m_brt[a-12] = (m_brt[a-12] & ~lm) | (bus_wdata & lm);
                if (a >= 16 && a < 20) m_win[a-16] = ((m_win[a-16] & ~lm) | (bus_wdata & lm)) & 16'h03FF;
                if (a >= 24 && a < 32 && bus_be[0]) m_pal[a-24] = bus_wdata & 16'h00FC;
            end
            m_pend = (m_pend & ~clr) | irq_evt;
            if ((m_pend & m_en) != 0) m_irq = 1;
            else if (m_pend == 0)     m_irq = 0;
            m_dstat_in = 16'(stat_fclk) << 7 | 16'(stat_scan_rdy) << 6 | 16'(stat_buf_busy) << 2;
            m_xstat_in = 16'(stat_group_out) << 15 | 16'(stat_group_cnt) << 8 |
                         16'(stat_overtime) << 4 | 16'(stat_fb_busy) << 2;
        end
    end

    function automatic logic [15:0] exp_read(input int a);
        if (a == 0)  return m_pend;
        if (a == 1)  return m_en;
        if (a == 3)  return m_dstat_in | 16'(m_lock) << 10 | 16'(m_sync) << 9 |
                            16'(m_ref) << 8 | 16'(m_disp) << 1;
        if (a == 5)  return 16'd2;
        if (a == 6)  return m_frm;
        if (a == 7)  return m_col;
        if (a == 8)  return m_xstat_in | 16'(m_draw) << 1;
        if (a == 10) return m_bkg;
        if (a >= 12 && a < 16) return m_brt[a-12];
        if (a >= 16 && a < 20) return m_win[a-16];
        if (a >= 24 && a < 32) return m_pal[a-24];
        return 16'h0000;
    endfunction

    function automatic string req_of(input int a);
        if (a == 0 || a == 2) return "R2";
        if (a == 1)  return "R1";
        if (a == 3 || a == 4) return "R8";
        if (a == 8 || a == 9) return "R9";
        if (a == 6 || a == 10) return "R6";
        if (a == 7 || (a >= 12 && a < 20)) return "R7";
        if (a >= 24 && a < 32) return "R4";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(req_of(int'(bus_addr)), bus_rdata, exp_read(int'(bus_addr)), "rdata");
        check("R3", 16'(irq), 16'(m_irq), "irq");
        check("R8", {12'h0, ctl_lock, ctl_sync_en, ctl_refresh_en, ctl_disp_en},
              {12'h0, m_lock, m_sync, m_ref, m_disp}, "display control outputs");
        check("R9", {10'h0, ctl_group_cmp, ctl_draw_en}, {10'h0, m_gcmp, m_draw},
              "drawing control outputs");
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr16(input int a, input logic [15:0] d, input logic [1:0] be);
        bus_addr = 6'(a); bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input int a, input logic [15:0] exp, input string tag);
        bus_addr = 6'(a); bus_wr = 1'b0;
        tick();
        check(tag, bus_rdata, exp, "directed read");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1'b1; bus_wr = 0; bus_be = 0; bus_addr = 0; bus_wdata = 0; irq_evt = 0;
        stat_fclk = 0; stat_scan_rdy = 0; stat_overtime = 0; stat_group_out = 0;
        stat_buf_busy = 0; stat_fb_busy = 0; stat_group_cnt = 0;
        repeat (3) tick();
        rst = 1'b0;

        // R11: everything zero after reset
        for (int a = 0; a < 64; a++) rd_expect(a, (a == 5) ? 16'd2 : 16'h0000, "R11");

        // R1: mask and lanes
        wr16(1, 16'hFFFF, 2'b11);
        rd_expect(1, 16'hE01F, "R1");
        wr16(1, 16'h0000, 2'b10);
        rd_expect(1, 16'h001F, "R1");

        // R2/R3: events, clears, latched request
        irq_evt = 16'h0005;
        tick();
        irq_evt = 16'h0000;
        check("R3", 16'(irq), 16'h1, "irq after enabled event");
        rd_expect(0, 16'h0005, "R2");
        wr16(1, 16'h0000, 2'b11);
        check("R3", 16'(irq), 16'h1, "irq held with enables removed");
        wr16(2, 16'h0001, 2'b11);
        rd_expect(0, 16'h0004, "R2");
        wr16(2, 16'h0004, 2'b10);
        rd_expect(0, 16'h0004, "R2");
        check("R3", 16'(irq), 16'h1, "irq held while pending nonzero");
        wr16(2, 16'h0004, 2'b01);
        rd_expect(0, 16'h0000, "R2");
        check("R3", 16'(irq), 16'h0, "irq drops when pending empty");
        irq_evt = 16'h0002;
        wr16(2, 16'h0002, 2'b11);
        irq_evt = 16'h0000;
        rd_expect(0, 16'h0002, "R2");
        check("R3", 16'(irq), 16'h0, "pending without enable keeps irq low");
        wr16(1, 16'h0002, 2'b01);
        check("R3", 16'(irq), 16'h1, "enable on existing pending raises irq");
        wr16(2, 16'hFFFF, 2'b11);

        // R4/R5: palettes
        wr16(24, 16'hFFFF, 2'b11);
        rd_expect(24, 16'h00FC, "R4");
        wr16(24, 16'h0000, 2'b10);
        rd_expect(24, 16'h00FC, "R5");
        wr16(31, 16'h0027, 2'b01);
        rd_expect(31, 16'h0024, "R4");

        // R6/R7: widths and lanes
        wr16(6, 16'hFFFF, 2'b11);
        rd_expect(6, 16'h000F, "R6");
        wr16(6, 16'h0000, 2'b10);
        rd_expect(6, 16'h000F, "R6");
        wr16(10, 16'hFFFF, 2'b11);
        rd_expect(10, 16'h0003, "R6");
        wr16(17, 16'hFFFF, 2'b11);
        wr16(17, 16'h0000, 2'b01);
        rd_expect(17, 16'h0300, "R7");
        wr16(14, 16'hABCD, 2'b11);
        wr16(14, 16'h1200, 2'b10);
        rd_expect(14, 16'h12CD, "R7");
        wr16(7, 16'h5A3C, 2'b01);
        rd_expect(7, 16'h003C, "R7");

        // R8/R12: display status
        bus_addr = 6'd3;
        stat_fclk = 1; stat_buf_busy = 4'b1010;
        #1;
        check("R12", bus_rdata, 16'h0000, "status not visible before edge");
        @(negedge clk);
        compare_all();
        check("R12", bus_rdata, 16'h00A8, "status visible after edge");
        wr16(4, 16'h0702, 2'b11);
        rd_expect(3, 16'h07AA, "R8");
        wr16(4, 16'h0000, 2'b01);
        rd_expect(3, 16'h07A8, "R8");

        // R9: drawing
        stat_group_out = 1; stat_group_cnt = 5'h15; stat_overtime = 1; stat_fb_busy = 2'b01;
        wr16(9, 16'h1F02, 2'b11);
        rd_expect(8, 16'h9516, "R9");
        check("R9", 16'(ctl_group_cmp), 16'h001F, "group compare output");
        rd_expect(9, 16'h0000, "R9");

        // R10: version, unmapped, read-only
        rd_expect(5, 16'h0002, "R10");
        wr16(11, 16'hFFFF, 2'b11);
        rd_expect(11, 16'h0000, "R10");
        wr16(5, 16'hFFFF, 2'b11);
        rd_expect(5, 16'h0002, "R10");
        wr16(0, 16'hFFFF, 2'b11);
        rd_expect(0, 16'h0000, "R10");
        rd_expect(45, 16'h0000, "R10");

        // Random phase: model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            bus_addr  = 6'($urandom_range(0, 63));
            bus_wdata = 16'($urandom);
            bus_be    = 2'($urandom);
            bus_wr    = ($urandom_range(0, 2) != 0);
            irq_evt   = ($urandom_range(0, 7) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            stat_fclk = 1'($urandom); stat_scan_rdy = 1'($urandom);
            stat_buf_busy = 4'($urandom); stat_overtime = 1'($urandom);
            stat_fb_busy = 2'($urandom); stat_group_out = 1'($urandom);
            stat_group_cnt = 5'($urandom);
            tick();
        end
        bus_wr = 0; irq_evt = 0;

        // R11: reset in the middle of a run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R11", 16'(irq), 16'h0, "irq after reset");
        check("R11", {10'h0, ctl_group_cmp, ctl_draw_en}, 16'h0000, "drawing control after reset");
        check("R11", {12'h0, ctl_lock, ctl_sync_en, ctl_refresh_en, ctl_disp_en}, 16'h0000,
              "display control after reset");
        rd_expect(1, 16'h0000, "R11");
        rd_expect(24, 16'h0000, "R11");
        rd_expect(14, 16'h0000, "R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule